// File: doc/BRIEF.md
# EPP Cycle Gate with Timeout

This block runs the enhanced-parallel-port transfer path of a byte-wide parallel port. A host issues register accesses over a simple request/busy/done handshake. Accesses to the EPP address offset or the EPP data offset turn into one or more byte cycles on the port. Each byte cycle raises an address or data strobe and waits for the peripheral's wait line. A byte cycle runs only when the low six bits of the control register hold the exact pattern for that direction. Any other access is dropped without touching the port.

Data-register accesses may be one, two or four bytes wide and are sent least significant byte first. Address-register accesses are always one byte. If a strobe sees no wait response within a programmable number of cycles, a sticky timeout flag is set and the rest of the access is abandoned. The flag shows in bit 0 of every status read, in place of the port's own bit 0. The host clears it by writing the status offset with bit 0 set.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset the control register reads 0xCC, the timeout flag is clear (status bit 0 reads 0), and host_busy is low.
- R2: A host write to offset 2 (control) stores the written byte with bits 7 and 6 forced to 1. A read of offset 2 returns that value, zero-extended. Reads of offsets 0, 5, 6 and 7 return 0xFF, and writes to them have no effect.
- R3: A write to offset 3 (EPP address) or offset 4 (EPP data) runs byte cycles only when control bits [5:0] masked with 0x2F equal 0x04. Otherwise no strobe is raised, the access completes at once, and the timeout flag is unchanged.
- R4: A read of offset 3 or 4 runs byte cycles only when control bits masked with 0x2F equal 0x24. Otherwise no strobe is raised, and the read returns all ones for its width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R5: The width code host_size selects the number of data-register bytes: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Write bytes go out on port_dout least significant first, each on data_strobe. An address-register access is always one byte on addr_strobe, whatever host_size is.
- R6: Read bytes taken from port_din are placed into host_rdata least significant first. Bits above the access width read as 0.
- R7: Each strobe is held until port_wait is seen, for at most tmo_limit cycles (a limit of 0 acts as 1). Each completed byte is followed by one cycle with both strobes low. If wait is never seen, the timeout flag is set and the remaining bytes are skipped. Read bytes that were never received return 0xFF.
- R8: The timeout flag is sticky. A read of offset 1 (status) returns port_status with bit 0 replaced by the flag. A write to offset 1 with data bit 0 equal to 1 clears the flag; with bit 0 equal to 0 the flag is left alone.
- R9: An accepted access raises host_busy until host_done pulses for one cycle. A register or dropped access is done one cycle after acceptance. An EPP access of n bytes with response delay d is done n*(d+2) cycles after acceptance. A request made while busy is ignored.
- R10: port_write is high during write byte cycles and low during read byte cycles. addr_strobe and data_strobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, taken when host_busy is low |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Register offset |
| host_size | input | 2 | Access width code for the data register |
| host_wdata | input | DW | Write data |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read result, valid with host_done |
| tmo_limit | input | TW | Maximum strobe cycles per byte |
| port_status | input | 8 | Status lines from the port |
| port_din | input | 8 | Data lines from the peripheral |
| port_dout | output | 8 | Data lines to the peripheral |
| port_write | output | 1 | Direction of the current byte cycle |
| addr_strobe | output | 1 | Address cycle strobe |
| data_strobe | output | 1 | Data cycle strobe |
| port_wait | input | 1 | Peripheral response to a strobe |

## Verification
The assertions assume that the peripheral raises port_wait only while a strobe is high and drops it as soon as the strobe falls. The bench's responder model builds wait from the strobes combinationally, so it stays within that assumption. The assertions also assume that the host sends its request only while host_busy is low, with one exception. The bench keeps to that rule except for one deliberate request during a busy window, and that request must leave both the control value and the in-flight bytes untouched.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_EADDR  = 3'd3;
  localparam logic [2:0] OFS_EDATA  = 3'd4;

  // control bits that take part in the cycle gate: dir, sel, init, lf, strobe
  localparam logic [7:0] CTL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTL_WR_READY  = 8'h04;
  localparam logic [7:0] CTL_RD_READY  = 8'h24;
  localparam logic [7:0] CTL_FORCED    = 8'hC0;
  localparam logic [7:0] CTL_RESET     = 8'hCC;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_STROBE,
    SQ_GAP,
    SQ_DONE
  } sq_state_e;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int DW    = 8 * BYTES,
  parameter int NBW   = $clog2(BYTES + 1)
) (
  input  logic [7:0]     ctrl,
  input  logic           tmo,
  input  logic [7:0]     port_status,
  input  logic           we,
  input  logic [2:0]     addr,
  input  logic [1:0]     size,
  output logic           run,
  output logic           is_addr,
  output logic [NBW-1:0] nbytes,
  output logic [DW-1:0]  rd_mask,
  output logic [DW-1:0]  imm_data
);
  logic is_epp;
  logic ready;
  logic [7:0] stat_view;
  int unsigned cnt;

  always_comb begin
    is_epp  = (addr == OFS_EADDR) || (addr == OFS_EDATA);
    is_addr = (addr == OFS_EADDR);
    if (is_addr || !is_epp) begin
      cnt = 1;
    end else begin
      cnt = 32'd1 << size;
    end
    if (cnt > BYTES) begin
      cnt = BYTES;
    end
    nbytes = NBW'(cnt);
    for (int b = 0; b < BYTES; b++) begin
      rd_mask[8*b +: 8] = (b < cnt) ? 8'hFF : 8'h00;
    end
  end

  always_comb begin
    ready     = (ctrl & CTL_GATE_MASK) == (we ? CTL_WR_READY : CTL_RD_READY);
    run       = is_epp && ready;
    stat_view = (port_status & 8'hFE) | {7'b0, tmo};
    imm_data  = rd_mask;
    if (!we && addr == OFS_STATUS) begin
      imm_data = {{(DW-8){1'b0}}, stat_view};
    end else if (!we && addr == OFS_CTRL) begin
      imm_data = {{(DW-8){1'b0}}, ctrl};
    end
  end
endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] ctrl_wdata,
  input  logic       tmo_set,
  input  logic       tmo_clr,
  output logic [7:0] ctrl,
  output logic       tmo
);
  logic [7:0] ctrl_d;
  logic       ctrl_en;
  logic       tmo_d;
  logic       tmo_en;

  always_comb begin
    ctrl_en = ctrl_wr;
    ctrl_d  = ctrl_wdata | CTL_FORCED;
    tmo_en  = tmo_set || tmo_clr;
    tmo_d   = tmo_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTL_RESET;
      tmo  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl <= ctrl_d;
      if (tmo_en)  tmo  <= tmo_d;
    end
  end
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int DW    = 8 * BYTES,
  parameter int NBW   = $clog2(BYTES + 1),
  parameter int TW    = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_run,
  input  logic           start_imm,
  input  logic           is_write,
  input  logic           is_addr,
  input  logic [NBW-1:0] nbytes,
  input  logic [DW-1:0]  wdata,
  input  logic [TW-1:0]  limit,
  input  logic           port_wait,
  input  logic [7:0]     port_din,
  output logic [7:0]     port_dout,
  output logic           port_write,
  output logic           addr_strobe,
  output logic           data_strobe,
  output logic           busy,
  output logic           done,
  output logic           tmo_hit,
  output logic [DW-1:0]  rdata
);
  sq_state_e      state_q, state_d;
  logic [NBW-1:0] idx_q, idx_d;
  logic [NBW-1:0] nb_q, nb_d;
  logic [TW-1:0]  cnt_q, cnt_d;
  logic [DW-1:0]  wbuf_q, wbuf_d;
  logic [DW-1:0]  rbuf_q, rbuf_d;
  logic           wr_q, wr_d;
  logic           adr_q, adr_d;
  logic           load;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    nb_d    = nb_q;
    cnt_d   = cnt_q;
    wbuf_d  = wbuf_q;
    rbuf_d  = rbuf_q;
    wr_d    = wr_q;
    adr_d   = adr_q;
    tmo_hit = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_run) begin
          load    = 1'b1;
          state_d = SQ_STROBE;
          idx_d   = '0;
          nb_d    = nbytes;
          cnt_d   = TW'(1);
          wbuf_d  = wdata;
          rbuf_d  = '1;
          wr_d    = is_write;
          adr_d   = is_addr;
        end else if (start_imm) begin
          state_d = SQ_DONE;
        end
      end
      SQ_STROBE: begin
        if (port_wait) begin
          if (!wr_q) begin
            for (int b = 0; b < BYTES; b++) begin
              if (NBW'(b) == idx_q) rbuf_d[8*b +: 8] = port_din;
            end
          end
          state_d = SQ_GAP;
        end else if (cnt_q >= limit) begin
          tmo_hit = 1'b1;
          state_d = SQ_DONE;
        end else begin
          cnt_d = cnt_q + TW'(1);
        end
      end
      SQ_GAP: begin
        if (idx_q == nb_q - NBW'(1)) begin
          state_d = SQ_DONE;
        end else begin
          idx_d   = idx_q + NBW'(1);
          cnt_d   = TW'(1);
          state_d = SQ_STROBE;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      nb_q    <= '0;
      cnt_q   <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '1;
      wr_q    <= 1'b0;
      adr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      rbuf_q  <= rbuf_d;
      if (load) begin
        nb_q   <= nb_d;
        wbuf_q <= wbuf_d;
        wr_q   <= wr_d;
        adr_q  <= adr_d;
      end
    end
  end

  always_comb begin
    busy        = (state_q != SQ_IDLE);
    done        = (state_q == SQ_DONE);
    addr_strobe = (state_q == SQ_STROBE) && adr_q;
    data_strobe = (state_q == SQ_STROBE) && !adr_q;
    port_write  = wr_q && ((state_q == SQ_STROBE) || (state_q == SQ_GAP));
    port_dout   = 8'(wbuf_q >> {idx_q, 3'b000});
    rdata       = rbuf_q;
  end
endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_pkg::*;
#(
  parameter int BYTES = 4,
  parameter int TW    = 8,
  localparam int DW   = 8 * BYTES,
  localparam int NBW  = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [2:0]    host_addr,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          host_done,
  output logic [DW-1:0] host_rdata,
  input  logic [TW-1:0] tmo_limit,
  input  logic [7:0]    port_status,
  input  logic [7:0]    port_din,
  output logic [7:0]    port_dout,
  output logic          port_write,
  output logic          addr_strobe,
  output logic          data_strobe,
  input  logic          port_wait
);
  logic [1:0]     rst_pipe;
  logic           rst_ns;
  logic [7:0]     ctrl;
  logic           tmo;
  logic           run;
  logic           is_addr;
  logic [NBW-1:0] nbytes;
  logic [DW-1:0]  rd_mask;
  logic [DW-1:0]  imm_data;
  logic           accept;
  logic           start_run;
  logic           start_imm;
  logic           ctrl_wr;
  logic           tmo_clr;
  logic           tmo_hit;
  logic [DW-1:0]  seq_rdata;
  logic [DW-1:0]  imm_q;
  logic [DW-1:0]  mask_q;
  logic           from_seq_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  epp_gate #(.BYTES(BYTES), .DW(DW), .NBW(NBW)) u_gate (
    .ctrl        (ctrl),
    .tmo         (tmo),
    .port_status (port_status),
    .we          (host_we),
    .addr        (host_addr),
    .size        (host_size),
    .run         (run),
    .is_addr     (is_addr),
    .nbytes      (nbytes),
    .rd_mask     (rd_mask),
    .imm_data    (imm_data)
  );

  always_comb begin
    accept    = host_req && !host_busy;
    start_run = accept && run;
    start_imm = accept && !run;
    ctrl_wr   = accept && host_we && (host_addr == OFS_CTRL);
    tmo_clr   = accept && host_we && (host_addr == OFS_STATUS) && host_wdata[0];
  end

  epp_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (host_wdata[7:0]),
    .tmo_set    (tmo_hit),
    .tmo_clr    (tmo_clr),
    .ctrl       (ctrl),
    .tmo        (tmo)
  );

  epp_byte_seq #(.BYTES(BYTES), .DW(DW), .NBW(NBW), .TW(TW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .start_run   (start_run),
    .start_imm   (start_imm),
    .is_write    (host_we),
    .is_addr     (is_addr),
    .nbytes      (nbytes),
    .wdata       (host_wdata),
    .limit       (tmo_limit),
    .port_wait   (port_wait),
    .port_din    (port_din),
    .port_dout   (port_dout),
    .port_write  (port_write),
    .addr_strobe (addr_strobe),
    .data_strobe (data_strobe),
    .busy        (host_busy),
    .done        (host_done),
    .tmo_hit     (tmo_hit),
    .rdata       (seq_rdata)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      imm_q      <= '1;
      mask_q     <= '1;
      from_seq_q <= 1'b0;
    end else if (accept) begin
      imm_q      <= imm_data;
      mask_q     <= rd_mask;
      from_seq_q <= run;
    end
  end

  assign host_rdata = from_seq_q ? (seq_rdata & mask_q) : imm_q;
endmodule

// File: rtl/epp_cycle_gate_chk.sv
module epp_cycle_gate_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_req,
  input logic          host_we,
  input logic [2:0]    host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_busy,
  input logic          host_done,
  input logic          port_write,
  input logic          addr_strobe,
  input logic          data_strobe,
  input logic          tmo
);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_strobe && data_strobe));

  // R10
  dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr_strobe || data_strobe) && $past(addr_strobe || data_strobe)) |-> $stable(port_write));

  // R9
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe || data_strobe) |-> host_busy);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_busy);

  // R7
  tmo_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(addr_strobe || data_strobe));

  // R8
  tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmo) |-> $past(host_req && !host_busy && host_we && host_addr == 3'd1 && host_wdata[0]));
endmodule

bind epp_cycle_gate epp_cycle_gate_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .host_we     (host_we),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_busy   (host_busy),
  .host_done   (host_done),
  .port_write  (port_write),
  .addr_strobe (addr_strobe),
  .data_strobe (data_strobe),
  .tmo         (tmo)
);

// File: tb/sim_epp_cycle_gate.sv
module sim_epp_cycle_gate;
  localparam int BYTES = 4;
  localparam int TW    = 8;
  localparam int DW    = 8 * BYTES;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0;
  logic          host_we = 1'b0;
  logic [2:0]    host_addr = '0;
  logic [1:0]    host_size = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_busy;
  logic          host_done;
  logic [DW-1:0] host_rdata;
  logic [TW-1:0] tmo_limit = TW'(4);
  logic [7:0]    port_status = 8'hFF;
  logic [7:0]    port_din;
  logic [7:0]    port_dout;
  logic          port_write;
  logic          addr_strobe;
  logic          data_strobe;
  logic          port_wait;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  epp_cycle_gate #(.BYTES(BYTES), .TW(TW)) u0 (.*);

  // peripheral responder model
  int nbytes = 0;
  int nstrobes = 0;
  int hcnt = 0;
  int delay = 0;
  int fail_abs = -1;
  logic [7:0] logb [1024];
  logic       loga [1024];
  logic       logw [1024];
  logic       strobe_prev = 1'b0;
  wire        strb = addr_strobe | data_strobe;

  function automatic logic [7:0] fval(int x);
    return 8'((x * 37 + 11) & 255);
  endfunction

  assign port_wait = strb && (hcnt >= delay) && (nbytes != fail_abs);
  assign port_din  = fval(nbytes);

  always @(posedge clk) begin
    hcnt <= strb ? hcnt + 1 : 0;
    strobe_prev <= strb;
    if (strb && !strobe_prev) nstrobes <= nstrobes + 1;
    if (port_wait) begin
      logb[nbytes % 1024] <= port_dout;
      loga[nbytes % 1024] <= addr_strobe;
      logw[nbytes % 1024] <= port_write;
      nbytes <= nbytes + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    cyc = 0;
    while (!host_done) begin
      cyc++;
      @(negedge clk);
    end
    rd = host_rdata;
  endtask

  task automatic setctl(input logic [7:0] v);
    logic [31:0] rd; int cyc;
    acc(1'b1, 3'd2, 2'd0, {24'h0, v}, rd, cyc);
  endtask

  task automatic rdstat(output logic [31:0] rd);
    int cyc;
    acc(1'b0, 3'd1, 2'd0, 32'h0, rd, cyc);
  endtask

  task automatic chklog(input int n0, input int cnt, input logic [31:0] wd,
                        input logic isaddr, input logic we, input string req);
    for (int k = 0; k < cnt; k++) begin
      chk(logb[(n0 + k) % 1024] == wd[8*k +: 8] && loga[(n0 + k) % 1024] == isaddr
          && logw[(n0 + k) % 1024] == we, req,
          {22'h0, logw[(n0 + k) % 1024], loga[(n0 + k) % 1024], logb[(n0 + k) % 1024]},
          {22'h0, we, isaddr, wd[8*k +: 8]});
    end
  endtask

  function automatic logic [31:0] rdexp(input int n0, input int cnt, input int got);
    logic [31:0] e = '0;
    for (int k = 0; k < cnt; k++) e[8*k +: 8] = (k < got) ? fval(n0 + k) : 8'hFF;
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, wd, e;
    int cyc, n0, s0, cnt;
    logic [7:0] c8;
    logic wok, rok;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(host_busy == 1'b0, "R1 busy", {31'h0, host_busy}, 32'h0);
    acc(1'b0, 3'd2, 2'd0, 32'h0, rd, cyc);
    chk(rd == 32'hCC, "R1 ctrl", rd, 32'hCC);
    rdstat(rd);
    chk(rd == 32'hFE, "R1 status", rd, 32'hFE);

    // R2 control write sweep
    for (int v = 0; v < 256; v++) begin
      setctl(8'(v));
      acc(1'b0, 3'd2, 2'd0, 32'h0, rd, cyc);
      chk(rd == (32'(v) | 32'hC0), "R2 ctrl readback", rd, 32'(v) | 32'hC0);
    end
    setctl(8'h04);
    for (int a = 0; a < 8; a++) begin
      if (a == 0 || a > 4) begin
        acc(1'b1, 3'(a), 2'd0, 32'h0000_0000, rd, cyc);
        acc(1'b0, 3'(a), 2'd0, 32'h0, rd, cyc);
        chk(rd == 32'hFF, "R2 unused offset", rd, 32'hFF);
        acc(1'b0, 3'd2, 2'd0, 32'h0, rd, cyc);
        chk(rd == 32'hC4, "R2 unused write no effect", rd, 32'hC4);
      end
    end

    // R3 R4 gate sweep over control bits 5:0
    delay = 0; tmo_limit = TW'(4);
    for (int c = 0; c < 64; c++) begin
      c8 = 8'(c);
      wok = ((c8 | 8'hC0) & 8'h2F) == 8'h04;
      rok = ((c8 | 8'hC0) & 8'h2F) == 8'h24;
      setctl(c8);
      wd = 32'h1357_9BDF + 32'(c) * 32'h0101_0101;
      n0 = nbytes; s0 = nstrobes;
      acc(1'b1, 3'd4, 2'd1, wd, rd, cyc);
      chk(nbytes - n0 == (wok ? 2 : 0) && nstrobes - s0 == (wok ? 2 : 0), "R3 data write gate",
          32'(nbytes - n0), wok ? 32'd2 : 32'd0);
      if (wok) chklog(n0, 2, wd, 1'b0, 1'b1, "R3 data write bytes");
      n0 = nbytes;
      acc(1'b1, 3'd3, 2'd0, wd, rd, cyc);
      chk(nbytes - n0 == (wok ? 1 : 0), "R3 addr write gate", 32'(nbytes - n0), wok ? 32'd1 : 32'd0);
      n0 = nbytes; s0 = nstrobes;
      acc(1'b0, 3'd4, 2'd1, 32'h0, rd, cyc);
      e = rok ? rdexp(n0, 2, 2) : 32'hFFFF;
      chk(rd == e && nstrobes - s0 == (rok ? 2 : 0), "R4 data read gate", rd, e);
      n0 = nbytes;
      acc(1'b0, 3'd3, 2'd2, 32'h0, rd, cyc);
      e = rok ? rdexp(n0, 1, 1) : 32'hFF;
      chk(rd == e, "R4 addr read gate", rd, e);
    end
    rdstat(rd);
    chk(rd[0] == 1'b0, "R3 no timeout from gated accesses", rd, {rd[31:1], 1'b0});

    // R5 R9 write widths
    setctl(8'h04);
    for (int sz = 0; sz < 4; sz++) begin
      cnt = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      wd = 32'hA1B2_C3D4 ^ (32'(sz) * 32'h1111_1111);
      n0 = nbytes;
      acc(1'b1, 3'd4, 2'(sz), wd, rd, cyc);
      chk(nbytes - n0 == cnt, "R5 write byte count", 32'(nbytes - n0), 32'(cnt));
      chklog(n0, cnt, wd, 1'b0, 1'b1, "R5 write order");
      chk(cyc == 2 * cnt, "R9 write timing", 32'(cyc), 32'(2 * cnt));
      n0 = nbytes;
      acc(1'b1, 3'd3, 2'(sz), wd, rd, cyc);
      chk(nbytes - n0 == 1, "R5 addr single byte", 32'(nbytes - n0), 32'd1);
      chklog(n0, 1, wd, 1'b1, 1'b1, "R5 addr byte");
    end

    // R6 R10 read widths
    setctl(8'h24);
    for (int sz = 0; sz < 4; sz++) begin
      cnt = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      n0 = nbytes;
      acc(1'b0, 3'd4, 2'(sz), 32'h0, rd, cyc);
      e = rdexp(n0, cnt, cnt);
      chk(rd == e, "R6 read assembly", rd, e);
      chk(logw[n0 % 1024] == 1'b0 && loga[n0 % 1024] == 1'b0, "R10 read direction",
          {30'h0, logw[n0 % 1024], loga[n0 % 1024]}, 32'h0);
      chk(cyc == 2 * cnt, "R9 read timing", 32'(cyc), 32'(2 * cnt));
    end

    // R7 R8 timeout sweep
    setctl(8'h04);
    port_status = 8'h5B;
    for (int lim = 1; lim <= 3; lim++) begin
      for (int d = 0; d <= lim + 1; d++) begin
        tmo_limit = TW'(lim); delay = d;
        n0 = nbytes;
        acc(1'b1, 3'd4, 2'd0, 32'h0000_0042, rd, cyc);
        e = (d >= lim) ? 32'(lim) : 32'(d + 2);
        chk(cyc == int'(e), "R7 strobe window", 32'(cyc), e);
        rdstat(rd);
        e = {24'h0, 8'h5A | ((d >= lim) ? 8'h01 : 8'h00)};
        chk(rd == e, "R8 status overlay", rd, e);
        acc(1'b1, 3'd1, 2'd0, 32'hFE, rd, cyc);
        rdstat(rd);
        chk(rd == e, "R8 write bit0 zero keeps flag", rd, e);
        acc(1'b1, 3'd1, 2'd0, 32'h01, rd, cyc);
        rdstat(rd);
        chk(rd == 32'h5A, "R8 clear flag", rd, 32'h5A);
      end
    end

    // R7 partial transfer on timeout
    delay = 1; tmo_limit = TW'(4);
    for (int fa = 0; fa < 4; fa++) begin
      setctl(8'h24);
      n0 = nbytes; s0 = nstrobes; fail_abs = n0 + fa;
      acc(1'b0, 3'd4, 2'd2, 32'h0, rd, cyc);
      fail_abs = -1;
      e = rdexp(n0, 4, fa);
      chk(rd == e, "R7 partial read", rd, e);
      chk(nstrobes - s0 == fa + 1, "R7 remaining bytes skipped", 32'(nstrobes - s0), 32'(fa + 1));
      chk(cyc == fa * 3 + 4, "R7 partial timing", 32'(cyc), 32'(fa * 3 + 4));
      rdstat(rd);
      chk(rd[0] == 1'b1, "R7 timeout flagged", rd, {rd[31:1], 1'b1});
      setctl(8'h04);
      n0 = nbytes; fail_abs = n0 + fa;
      wd = 32'hDEAD_BEEF;
      acc(1'b1, 3'd4, 2'd2, wd, rd, cyc);
      fail_abs = -1;
      chk(nbytes - n0 == fa, "R7 partial write", 32'(nbytes - n0), 32'(fa));
      chklog(n0, fa, wd, 1'b0, 1'b1, "R7 partial write bytes");
      acc(1'b1, 3'd1, 2'd0, 32'h01, rd, cyc);
    end

    // R9 request while busy is ignored
    setctl(8'h04);
    delay = 3; tmo_limit = TW'(8);
    n0 = nbytes;
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 3'd4; host_size = 2'd0; host_wdata = 32'h77;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_busy == 1'b1, "R9 busy after accept", {31'h0, host_busy}, 32'h1);
    @(negedge clk);
    host_req = 1'b1; host_addr = 3'd2; host_wdata = 32'h20;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_done) @(negedge clk);
    @(negedge clk);
    chk(host_done == 1'b0 && host_busy == 1'b0, "R9 done is one pulse", {30'h0, host_busy, host_done}, 32'h0);
    chklog(n0, 1, 32'h77, 1'b0, 1'b1, "R9 in-flight byte kept");
    acc(1'b0, 3'd2, 2'd0, 32'h0, rd, cyc);
    chk(rd == 32'hC4, "R9 busy request ignored", rd, 32'hC4);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule